// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Window

This block lets a host reach a device-internal memory and a bank of internal peripheral registers through a small set of host-visible registers. Memory traffic uses two independent pointers. A write pointer is used by a write-data register, and a read pointer is used by a read-data register. Every data access moves its own pointer on by one 32-bit word, so the host can stream a buffer in either direction after programming one address.

Reads are prefetched. Loading the read pointer starts a memory read at once. Each access to the read-data register returns the buffered word and launches the fetch of the following word. The peripheral side uses a configuration register per direction. Each holds a 16-bit register offset and a 2-bit transfer size, coded as bytes minus one. Narrow transfers use the low byte lanes.

The internal side is a request bus. A request stays asserted, with stable fields, until the target acknowledges it. While a request is outstanding the host port is not ready.

Top module: `iwin_top`

## Requirements
- R1: After reset, `hst_ready` is 1, `mem_req` is 0, `hst_rvalid` is 0, and both memory pointers and both peripheral configurations read back as 0.
- R2: A host write to register 0 (memory read pointer) loads the pointer and issues a memory read (`mem_sel`=0, `mem_we`=0) at the written address. The next read of register 3 (memory read data) returns the word stored at that address.
- R3: Each read of register 3 advances the read pointer by 4 and fetches the next word. Successive reads therefore return consecutive words.
- R4: Each host write to register 2 (memory write data) issues a memory write with all four byte enables at the current write pointer. The write pointer (register 1) then advances by 4.
- R5: The read pointer and the write pointer are independent. Loading or advancing one never changes the other.
- R6: Pointer increments wrap modulo 2^32, so a pointer at 0xFFFFFFFC steps to 0x00000000.
- R7: While `mem_req` is 1, `hst_ready` is 0. `mem_req`, `mem_addr`, `mem_we` and `mem_sel` hold until `mem_ack`.
- R8: A host write to register 6 (peripheral write data) issues a request with `mem_sel`=1 and `mem_we`=1. The address is the offset held in bits [15:0] of register 4, with its upper bits zero. The byte enables come from the size in bits [25:24] of register 4: 0 gives 0001, 1 gives 0011, 2 gives 0111 and 3 gives 1111.
- R9: A host read of register 7 (peripheral read data) issues a peripheral read at the offset in register 5. It returns the response with every byte above the size in register 5 bits [25:24] forced to zero.
- R10: Host register indices are: 0 memory read pointer, 1 memory write pointer, 2 memory write data, 3 memory read data, 4 peripheral write config, 5 peripheral read config, 6 peripheral write data, 7 peripheral read data. Registers 0 and 1 read back their pointer. Registers 4 and 5 read back only bits [25:24] and [15:0], with all other bits 0. Registers 2 and 6 read as 0.
- R11: A read of register 3 before the read pointer has ever been loaded returns 0 and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_valid | input | 1 | Host access request |
| hst_write | input | 1 | 1 for write access, 0 for read access |
| hst_reg | input | 3 | Host register index |
| hst_wdata | input | 32 | Host write data |
| hst_ready | output | 1 | Host access accepted when high together with hst_valid |
| hst_rvalid | output | 1 | Host read data valid pulse |
| hst_rdata | output | 32 | Host read data |
| mem_req | output | 1 | Internal request outstanding |
| mem_sel | output | 1 | 0 memory space, 1 peripheral space |
| mem_we | output | 1 | Internal request is a write |
| mem_addr | output | 32 | Internal byte address |
| mem_wdata | output | 32 | Internal write data |
| mem_be | output | 4 | Internal byte enables |
| mem_ack | input | 1 | Internal request completion |
| mem_rdata | input | 32 | Internal read data, valid with mem_ack |

## Verification
Directed streams cover several cases:
- a write burst followed by a read burst at the same base, which shows that data lands at consecutive words and comes back in order;
- interleaved pointer loads, which show that the two pointers do not disturb each other;
- a stream that crosses 0xFFFFFFFC, which separates a wrapping increment from a saturating or carrying one.

Random bursts of random length and base, with random data, check against a bench shadow memory for the streaming function. Every size code is used for peripheral writes and reads, so byte-lane errors appear both as wrong enables on the bus and as unmasked read bytes. The target model acknowledges after a random delay of one to three cycles, which exercises the stall on the host port.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

    localparam int IW_AW      = 32;
    localparam int IW_DW      = 32;
    localparam int IW_BYTES   = IW_DW / 8;
    localparam int PER_OFS_W  = 16;
    localparam int SIZE_LSB   = 24;
    localparam int SIZE_W     = 2;

    typedef enum logic [2:0] {
        REG_MRD_PTR  = 3'd0,
        REG_MWR_PTR  = 3'd1,
        REG_MWR_DATA = 3'd2,
        REG_MRD_DATA = 3'd3,
        REG_PWR_CFG  = 3'd4,
        REG_PRD_CFG  = 3'd5,
        REG_PWR_DATA = 3'd6,
        REG_PRD_DATA = 3'd7
    } host_reg_e;

    typedef enum logic [1:0] {
        KIND_PREFETCH = 2'd0,
        KIND_MEM_WR   = 2'd1,
        KIND_PER_WR   = 2'd2,
        KIND_PER_RD   = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic [SIZE_W-1:0]    size;
        logic [PER_OFS_W-1:0] ofs;
    } per_cfg_t;

    function automatic logic [IW_BYTES-1:0] lanes_from_size(input logic [SIZE_W-1:0] size);
        logic [IW_BYTES-1:0] be;
        for (int i = 0; i < IW_BYTES; i++) be[i] = (i <= int'(size));
        return be;
    endfunction

    function automatic logic [IW_DW-1:0] mask_from_size(input logic [SIZE_W-1:0] size);
        logic [IW_BYTES-1:0] be;
        logic [IW_DW-1:0]    m;
        be = lanes_from_size(size);
        for (int i = 0; i < IW_BYTES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [IW_DW-1:0] cfg_readback(input per_cfg_t c);
        logic [IW_DW-1:0] v;
        v = '0;
        v[PER_OFS_W-1:0]             = c.ofs;
        v[SIZE_LSB +: SIZE_W]        = c.size;
        return v;
    endfunction

endpackage

// File: rtl/iwin_ptr.sv
module iwin_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] q,
    output logic [AW-1:0] q_next_word
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    assign q_next_word = q + STEP_V;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q_next_word;
    end
endmodule

// File: rtl/iwin_bus_port.sv
module iwin_bus_port
    import iwin_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  req_kind_e     issue_kind,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] issue_data,
    input  logic [BW-1:0] issue_be,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_sel,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [BW-1:0] mem_be,
    output req_kind_e     kind_q,
    output logic          done
);
    assign done = mem_req && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            mem_sel   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
            kind_q    <= KIND_PREFETCH;
        end else if (issue) begin
            mem_req   <= 1'b1;
            mem_sel   <= (issue_kind == KIND_PER_WR) || (issue_kind == KIND_PER_RD);
            mem_we    <= (issue_kind == KIND_MEM_WR) || (issue_kind == KIND_PER_WR);
            mem_addr  <= issue_addr;
            mem_wdata <= issue_data;
            mem_be    <= issue_be;
            kind_q    <= issue_kind;
        end else if (done) begin
            mem_req   <= 1'b0;
        end
    end
endmodule

// File: rtl/iwin_top.sv
module iwin_top
    import iwin_pkg::*;
#(
    parameter int ADDR_W = IW_AW,
    parameter int DATA_W = IW_DW,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_valid,
    input  logic              hst_write,
    input  logic [2:0]        hst_reg,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic              hst_ready,
    output logic              hst_rvalid,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              mem_req,
    output logic              mem_sel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int STEP_BYTES = BE_W;

    host_reg_e reg_sel;
    logic      wr_acc, rd_acc;
    assign reg_sel   = host_reg_e'(hst_reg);
    assign wr_acc    = hst_valid && hst_ready && hst_write;
    assign rd_acc    = hst_valid && hst_ready && !hst_write;

    // pointers: index 0 read side, index 1 write side
    logic [1:0]             p_load, p_inc;
    logic [ADDR_W-1:0]      p_q   [2];
    logic [ADDR_W-1:0]      p_nxt [2];

    logic                   buf_vld;
    logic [DATA_W-1:0]      buf_data;

    assign p_load[0] = wr_acc && reg_sel == REG_MRD_PTR;
    assign p_inc[0]  = rd_acc && reg_sel == REG_MRD_DATA && buf_vld;
    assign p_load[1] = wr_acc && reg_sel == REG_MWR_PTR;
    assign p_inc[1]  = wr_acc && reg_sel == REG_MWR_DATA;

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        iwin_ptr #(.AW(ADDR_W), .STEP(STEP_BYTES)) u_ptr (
            .clk        (clk),
            .rst        (rst),
            .load       (p_load[g]),
            .load_val   (hst_wdata[ADDR_W-1:0]),
            .inc        (p_inc[g]),
            .q          (p_q[g]),
            .q_next_word(p_nxt[g])
        );
    end

    per_cfg_t pwr_cfg, prd_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_cfg <= '0;
            prd_cfg <= '0;
        end else if (wr_acc) begin
            if (reg_sel == REG_PWR_CFG)
                pwr_cfg <= '{size: hst_wdata[SIZE_LSB +: SIZE_W], ofs: hst_wdata[PER_OFS_W-1:0]};
            if (reg_sel == REG_PRD_CFG)
                prd_cfg <= '{size: hst_wdata[SIZE_LSB +: SIZE_W], ofs: hst_wdata[PER_OFS_W-1:0]};
        end
    end

    // request selection
    logic              issue;
    req_kind_e         issue_kind;
    logic [ADDR_W-1:0] issue_addr;
    logic [BE_W-1:0]   issue_be;

    always_comb begin
        issue      = 1'b0;
        issue_kind = KIND_PREFETCH;
        issue_addr = p_nxt[0];
        issue_be   = '1;
        if (p_load[0]) begin
            issue      = 1'b1;
            issue_addr = hst_wdata[ADDR_W-1:0];
        end else if (p_inc[0]) begin
            issue      = 1'b1;
        end else if (p_inc[1]) begin
            issue      = 1'b1;
            issue_kind = KIND_MEM_WR;
            issue_addr = p_q[1];
        end else if (wr_acc && reg_sel == REG_PWR_DATA) begin
            issue      = 1'b1;
            issue_kind = KIND_PER_WR;
            issue_addr = ADDR_W'(pwr_cfg.ofs);
            issue_be   = lanes_from_size(pwr_cfg.size);
        end else if (rd_acc && reg_sel == REG_PRD_DATA) begin
            issue      = 1'b1;
            issue_kind = KIND_PER_RD;
            issue_addr = ADDR_W'(prd_cfg.ofs);
            issue_be   = lanes_from_size(prd_cfg.size);
        end
    end

    req_kind_e kind_q;
    logic      done;

    iwin_bus_port #(.AW(ADDR_W), .DW(DATA_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .issue_kind(issue_kind),
        .issue_addr(issue_addr),
        .issue_data(hst_wdata),
        .issue_be  (issue_be),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_sel   (mem_sel),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .kind_q    (kind_q),
        .done      (done)
    );

    assign hst_ready = !mem_req;

    // prefetch buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_vld  <= 1'b0;
            buf_data <= '0;
        end else if (issue && issue_kind == KIND_PREFETCH) begin
            buf_vld  <= 1'b0;
        end else if (done && kind_q == KIND_PREFETCH) begin
            buf_vld  <= 1'b1;
            buf_data <= mem_rdata;
        end
    end

    // host read response
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        unique case (reg_sel)
            REG_MRD_PTR:  rd_mux = DATA_W'(p_q[0]);
            REG_MWR_PTR:  rd_mux = DATA_W'(p_q[1]);
            REG_MRD_DATA: rd_mux = buf_vld ? buf_data : '0;
            REG_PWR_CFG:  rd_mux = cfg_readback(pwr_cfg);
            REG_PRD_CFG:  rd_mux = cfg_readback(prd_cfg);
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rvalid <= 1'b0;
            hst_rdata  <= '0;
        end else if (done && kind_q == KIND_PER_RD) begin
            hst_rvalid <= 1'b1;
            hst_rdata  <= mem_rdata & mask_from_size(prd_cfg.size);
        end else if (rd_acc && reg_sel != REG_PRD_DATA) begin
            hst_rvalid <= 1'b1;
            hst_rdata  <= rd_mux;
        end else begin
            hst_rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/iwin_chk.sv
module iwin_chk (
    input logic        clk,
    input logic        rst,
    input logic        hst_valid,
    input logic        hst_write,
    input logic [2:0]  hst_reg,
    input logic [31:0] hst_wdata,
    input logic        hst_ready,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_sel,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be
);
    logic host_wr;
    assign host_wr = hst_valid && hst_ready && hst_write;

    p_stall_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !hst_ready);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_sel)));

    p_prefetch_on_load_r2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && hst_reg == 3'd0) |=> (mem_req && !mem_we && !mem_sel && mem_addr == $past(hst_wdata)));

    p_full_word_write_r4: assert property (@(posedge clk) disable iff (rst)
        (host_wr && hst_reg == 3'd2) |=> (mem_req && mem_we && !mem_sel && mem_be == 4'hF));

    p_per_request_shape_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_sel) |-> (mem_addr[31:16] == 16'h0 &&
            (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF)));
endmodule

bind iwin_top iwin_chk u_iwin_chk (
    .clk      (clk),
    .rst      (rst),
    .hst_valid(hst_valid),
    .hst_write(hst_write),
    .hst_reg  (hst_reg),
    .hst_wdata(hst_wdata),
    .hst_ready(hst_ready),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_sel  (mem_sel),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be)
);

// File: tb/test_iwin_top.sv
`timescale 1ns/1ps
module test_iwin_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_valid = 1'b0, hst_write = 1'b0;
    logic [2:0]  hst_reg = 3'd0;
    logic [31:0] hst_wdata = 32'h0;
    logic        hst_ready, hst_rvalid;
    logic [31:0] hst_rdata;
    logic        mem_req, mem_sel, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    iwin_top i_iwin_top (
        .clk(clk), .rst(rst), .hst_valid(hst_valid), .hst_write(hst_write),
        .hst_reg(hst_reg), .hst_wdata(hst_wdata), .hst_ready(hst_ready),
        .hst_rvalid(hst_rvalid), .hst_rdata(hst_rdata), .mem_req(mem_req),
        .mem_sel(mem_sel), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // target model: memory (256 words) and peripheral bank (16 words)
    logic [31:0] mem_arr [256];
    logic [31:0] per_arr [16];
    logic [31:0] mem_shadow [256];
    logic [31:0] per_shadow [16];
    int          lat = 0;

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        return (sz == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (int'(sz) + 1))) - 32'h1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= 32'h0;
            lat       <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat == 0) begin
                    mem_ack <= 1'b1;
                    lat     <= int'($urandom % 3);
                    if (!mem_sel) begin
                        if (mem_we) mem_arr[mem_addr[9:2]] <= mem_wdata;
                        else        mem_rdata <= mem_arr[mem_addr[9:2]];
                    end else begin
                        if (mem_we) begin
                            for (int b = 0; b < 4; b++)
                                if (mem_be[b]) per_arr[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                        end else mem_rdata <= per_arr[mem_addr[3:0]];
                    end
                end else lat <= lat - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] r, input logic [31:0] d);
        @(negedge clk);
        while (!hst_ready) @(negedge clk);
        hst_valid = 1'b1; hst_write = 1'b1; hst_reg = r; hst_wdata = d;
        @(negedge clk);
        hst_valid = 1'b0; hst_write = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] r, output logic [31:0] d);
        @(negedge clk);
        while (!hst_ready) @(negedge clk);
        hst_valid = 1'b1; hst_write = 1'b0; hst_reg = r;
        @(negedge clk);
        hst_valid = 1'b0;
        while (!hst_rvalid) @(negedge clk);
        d = hst_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, base, d, cfg;
        logic [1:0]  sz;
        logic [15:0] ofs;
        int          len;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
            mem_shadow[i] = mem_arr[i];
        end
        for (int i = 0; i < 16; i++) begin
            per_arr[i] = 32'hC3C3_0000 + i * 32'h1111;
            per_shadow[i] = per_arr[i];
        end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk(hst_ready && !mem_req && !hst_rvalid, "R1 idle outputs", {29'b0, hst_ready, mem_req, hst_rvalid}, 32'h4);
        for (int r = 0; r < 2; r++) begin
            hrd(3'(r), v); chk(v == 32'h0, "R1 pointer reset", v, 32'h0);
        end
        hrd(3'd4, v); chk(v == 32'h0, "R1 config reset", v, 32'h0);

        // R11 read data before pointer load
        hrd(3'd3, v); chk(v == 32'h0, "R11 unprogrammed read", v, 32'h0);
        @(negedge clk); chk(!mem_req, "R11 no request", {31'b0, mem_req}, 32'h0);

        // R2 / R3 directed stream
        hwr(3'd0, 32'h0000_0040);
        for (int j = 0; j < 4; j++) begin
            hrd(3'd3, v); chk(v == mem_shadow[16 + j], "R3 stream read", v, mem_shadow[16 + j]);
        end
        hrd(3'd0, v); chk(v == 32'h50, "R3 read pointer advanced", v, 32'h50);

        // R4 / R7 directed write
        hwr(3'd1, 32'h0000_0100);
        @(negedge clk); while (!hst_ready) @(negedge clk);
        hst_valid = 1'b1; hst_write = 1'b1; hst_reg = 3'd2; hst_wdata = 32'hDEAD_BEEF;
        @(negedge clk); hst_valid = 1'b0;
        chk(mem_req && !hst_ready, "R7 stall while outstanding", {30'b0, mem_req, hst_ready}, 32'h2);
        chk(mem_addr == 32'h100 && mem_be == 4'hF, "R4 write address", mem_addr, 32'h100);
        mem_shadow[64] = 32'hDEAD_BEEF;
        hwr(3'd2, 32'h1234_5678); mem_shadow[65] = 32'h1234_5678;
        hrd(3'd1, v); chk(v == 32'h108, "R4 write pointer advanced", v, 32'h108);

        // R5 independence
        hrd(3'd0, v); chk(v == 32'h50, "R5 read pointer untouched", v, 32'h50);
        hwr(3'd0, 32'h0000_0100);
        hrd(3'd1, v); chk(v == 32'h108, "R5 write pointer untouched", v, 32'h108);
        hrd(3'd3, v); chk(v == 32'hDEAD_BEEF, "R2 first word after load", v, 32'hDEAD_BEEF);
        hrd(3'd3, v); chk(v == 32'h1234_5678, "R3 second word", v, 32'h1234_5678);

        // R6 wrap
        hwr(3'd1, 32'hFFFF_FFFC);
        hwr(3'd2, 32'hAAAA_0001); mem_shadow[255] = 32'hAAAA_0001;
        hwr(3'd2, 32'hAAAA_0002); mem_shadow[0]   = 32'hAAAA_0002;
        hrd(3'd1, v); chk(v == 32'h4, "R6 write pointer wrap", v, 32'h4);
        hwr(3'd0, 32'hFFFF_FFFC);
        hrd(3'd3, v); chk(v == 32'hAAAA_0001, "R6 read at top", v, 32'hAAAA_0001);
        hrd(3'd3, v); chk(v == 32'hAAAA_0002, "R6 read after wrap", v, 32'hAAAA_0002);
        hrd(3'd0, v); chk(v == 32'h4, "R6 read pointer wrap", v, 32'h4);

        // R8 / R9 / R10 directed peripheral, every size
        for (int s = 0; s < 4; s++) begin
            ofs = 16'hA5F0 + 16'(s);
            cfg = 32'hF0F0_0000 | (32'(s) << 24) | 32'(ofs);
            hwr(3'd4, cfg);
            hrd(3'd4, v); chk(v == (cfg & 32'h0300_FFFF), "R10 config readback", v, cfg & 32'h0300_FFFF);
            @(negedge clk); while (!hst_ready) @(negedge clk);
            hst_valid = 1'b1; hst_write = 1'b1; hst_reg = 3'd6; hst_wdata = 32'h8877_6655;
            @(negedge clk); hst_valid = 1'b0;
            chk(mem_sel && mem_we && mem_addr == 32'(ofs), "R8 peripheral address", mem_addr, 32'(ofs));
            chk(mem_be == 4'((1 << (s + 1)) - 1), "R8 byte enables", {28'b0, mem_be}, 32'((1 << (s + 1)) - 1));
            per_shadow[ofs[3:0]] = (per_shadow[ofs[3:0]] & ~lane_mask(2'(s))) | (32'h8877_6655 & lane_mask(2'(s)));
            hwr(3'd5, 32'(ofs) | 32'h0300_0000);
            hrd(3'd7, v); chk(v == per_shadow[ofs[3:0]], "R9 full read", v, per_shadow[ofs[3:0]]);
        end
        hrd(3'd2, v); chk(v == 32'h0, "R10 write-data reads zero", v, 32'h0);
        hrd(3'd6, v); chk(v == 32'h0, "R10 peripheral write-data reads zero", v, 32'h0);

        // random memory bursts: R3 R4
        for (int it = 0; it < 40; it++) begin
            base = {$urandom} & 32'hFFFF_FFFC;
            len  = 1 + int'($urandom % 5);
            hwr(3'd1, base);
            for (int j = 0; j < len; j++) begin
                d = $urandom;
                hwr(3'd2, d);
                mem_shadow[8'(base[9:2] + 8'(j))] = d;
            end
            hrd(3'd1, v); chk(v == base + 32'(4 * len), "R4 random write pointer", v, base + 32'(4 * len));
            hwr(3'd0, base);
            for (int j = 0; j < len; j++) begin
                hrd(3'd3, v);
                chk(v == mem_shadow[8'(base[9:2] + 8'(j))], "R3 random stream", v, mem_shadow[8'(base[9:2] + 8'(j))]);
            end
        end

        // random peripheral: R8 R9
        for (int it = 0; it < 30; it++) begin
            ofs = 16'($urandom);
            sz  = 2'($urandom);
            d   = $urandom;
            hwr(3'd4, 32'(ofs) | (32'(sz) << 24));
            hwr(3'd6, d);
            per_shadow[ofs[3:0]] = (per_shadow[ofs[3:0]] & ~lane_mask(sz)) | (d & lane_mask(sz));
            sz = 2'($urandom);
            hwr(3'd5, 32'(ofs) | (32'(sz) << 24) | 32'h4000_0000);
            hrd(3'd7, v);
            chk(v == (per_shadow[ofs[3:0]] & lane_mask(sz)), "R9 masked peripheral read", v, per_shadow[ofs[3:0]] & lane_mask(sz));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule